// File: doc/BRIEF.md
# Destination Address Hash Filter

This block decides whether a received Ethernet frame passes the receive filter, judging only by its 48-bit destination address. As the six address bytes arrive, the block folds them into a 6-bit index. The index picks one bit out of a 64-bit hash table that software programs. Hash matching has two separate enables: one applies to multicast addresses and one to unicast addresses. The first address bit received decides which of the two applies. A copy-all setting passes every frame whatever the hash result is.

A one-cycle `frame_start` pulse begins a new frame. It clears the index accumulator and any previous decision. Address bytes follow on `byte_data`, each one qualified by `byte_valid`, and idle cycles between bytes are allowed. The decision appears in the cycle after the sixth byte is taken. It stays on the outputs until the next `frame_start`. The control bits and the hash table are written through a small word-wide write port.

The sequencing is done by a three-state machine:
- ST_IDLE: the state after reset.
- ST_COLLECT: entered from any state when `frame_start` is seen. It counts valid bytes and stays here until the sixth one arrives.
- ST_HOLD: entered from ST_COLLECT on the sixth byte. It keeps the decision and leaves only when `frame_start` is seen again.

Top module: `addr_hash_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept`, `dec_mcast` and `dec_hash_hit` are 0. The control bits and all 64 hash bits are 0, so a frame sent before any write is rejected.
- R2: The write port decodes `cfg_addr` as follows:
  - 0 is the control word: bit 0 = copy-all, bit 1 = unicast hash enable, bit 2 = multicast hash enable.
  - 1 holds hash bits 31:0.
  - 2 holds hash bits 63:32.
  - A write to address 3 has no effect.
- R3: A byte is taken only when `byte_valid` is 1 and the block is collecting. `dec_valid` is still 0 in the cycle the sixth byte is presented and becomes 1 in the following cycle.
- R4: Let da[n] denote the address bits, where da[8k+i] is bit i of the k-th byte received, counting k from 0. Bit j of the hash index is the XOR of da[j], da[j+6], da[j+12], up to da[j+42]. The index selects hash bit number index, counted from bit 0 of the address-1 word.
- R5: `dec_mcast` equals da[0]. When da[0] is 1, a hash hit requires the multicast enable and the selected hash bit to be 1.
- R6: When da[0] is 0, a hash hit requires the unicast enable and the selected hash bit to be 1.
- R7: `dec_hash_hit` reports only the hash hit. `dec_accept` is the copy-all bit OR the hash hit.
- R8: A `frame_start` pulse drives `dec_valid` to 0 in the next cycle and restarts the collection. A byte presented in the same cycle as `frame_start` is not taken.
- R9: Once valid, the decision holds until the next `frame_start`. Further valid bytes and register writes do not change it.
- R10: With all 64 hash bits at 1 and only the multicast enable set, every multicast address is accepted and every unicast address is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that begins a new frame |
| byte_valid | input | 1 | Qualifies `byte_data` |
| byte_data | input | 8 | Destination address byte, first received byte first |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word select |
| cfg_wdata | input | 32 | Register write data |
| dec_valid | output | 1 | Decision is available |
| dec_accept | output | 1 | Frame passes the filter |
| dec_mcast | output | 1 | Address is multicast (da[0]) |
| dec_hash_hit | output | 1 | Hash match by itself, without copy-all |

## Verification
The bench sweeps all 64 index values. For each value it uses a one-hot table set at that index and at its neighbour. A design that folds bits at the wrong stride, or that swaps the two hash words, therefore selects a wrong bit and misses the hit.

The bench also covers every combination of the three control bits against several hash patterns, with both unicast and multicast addresses. This catches an enable that is applied to the wrong address kind, and a copy-all bit that leaks into the hash-hit output.

Idle gaps between bytes, a byte placed in the `frame_start` cycle, and bytes and register writes sent after the decision are also exercised. A design that counts unqualified bytes, takes the start-cycle byte, or recomputes the decision after it is valid changes its outputs and is reported.

// File: rtl/hfilt_pkg.sv
package hfilt_pkg;

    localparam int unsigned HF_BYTE_W     = 8;
    localparam int unsigned HF_ADDR_BYTES = 6;
    localparam int unsigned HF_IDX_W      = 6;
    localparam int unsigned HF_TBL_BITS   = 1 << HF_IDX_W;
    localparam int unsigned HF_POS_W      = $clog2(HF_ADDR_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_HOLD    = 2'd2
    } hf_state_t;

    typedef struct packed {
        logic mc_en;
        logic uc_en;
        logic copy_all;
    } hf_ctrl_t;

    // Contribution of one address byte to the folded index.
    // Bit i of byte number pos is address bit 8*pos+i, which feeds index bit (8*pos+i) mod 6.
    function automatic logic [HF_IDX_W-1:0] hf_fold_byte(
        input logic [HF_BYTE_W-1:0] b,
        input logic [HF_POS_W-1:0]  pos
    );
        logic [HF_IDX_W-1:0] r;
        int unsigned n;
        r = '0;
        for (int unsigned i = 0; i < HF_BYTE_W; i++) begin
            n = int'(pos) * HF_BYTE_W + i;
            r[n % HF_IDX_W] = r[n % HF_IDX_W] ^ b[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/hfilt_cfg_regs.sv
module hfilt_cfg_regs
    import hfilt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    output hf_ctrl_t               ctrl,
    output logic [HF_TBL_BITS-1:0] hash_tbl
);

    localparam int unsigned NWORDS = HF_TBL_BITS / DATA_W;

    // Address 0: control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(0)) begin
            ctrl.copy_all <= wr_data[0];
            ctrl.uc_en    <= wr_data[1];
            ctrl.mc_en    <= wr_data[2];
        end
    end

    // Addresses 1..NWORDS: hash table words, lowest bits first
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(w + 1)) begin
                word_q <= wr_data;
            end
        end
        assign hash_tbl[w*DATA_W +: DATA_W] = word_q;
    end

endmodule

// File: rtl/hfilt_index_acc.sv
module hfilt_index_acc
    import hfilt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 take,
    input  logic [HF_POS_W-1:0]  pos,
    input  logic [HF_BYTE_W-1:0] byte_in,
    output logic [HF_IDX_W-1:0]  idx_nxt,
    output logic                 da0_q
);

    logic [HF_IDX_W-1:0] idx_q;

    always_comb begin
        idx_nxt = idx_q;
        if (take) begin
            idx_nxt = idx_q ^ hf_fold_byte(byte_in, pos);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            da0_q <= 1'b0;
        end else if (clear) begin
            idx_q <= '0;
            da0_q <= 1'b0;
        end else if (take) begin
            idx_q <= idx_nxt;
            if (pos == '0) begin
                da0_q <= byte_in[0];
            end
        end
    end

endmodule

// File: rtl/hfilt_ctrl.sv
module hfilt_ctrl
    import hfilt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                byte_valid,
    input  logic                accept_now,
    input  logic                mcast_now,
    input  logic                hit_now,
    output logic                take,
    output logic [HF_POS_W-1:0] pos,
    output logic                dec_valid,
    output logic                dec_accept,
    output logic                dec_mcast,
    output logic                dec_hash_hit
);

    localparam logic [HF_POS_W-1:0] LAST_POS = HF_POS_W'(HF_ADDR_BYTES - 1);

    hf_state_t state_q, state_d;
    logic      last;

    assign take = byte_valid && !frame_start && (state_q == ST_COLLECT);
    assign last = take && (pos == LAST_POS);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (frame_start) state_d = ST_COLLECT;
            ST_COLLECT: if (!frame_start && last) state_d = ST_HOLD;
            ST_HOLD:    if (frame_start) state_d = ST_COLLECT;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and byte position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos     <= '0;
        end else begin
            state_q <= state_d;
            if (frame_start) begin
                pos <= '0;
            end else if (take) begin
                pos <= pos + 1'b1;
            end
        end
    end

    // Decision outputs
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            dec_valid    <= 1'b0;
            dec_accept   <= 1'b0;
            dec_mcast    <= 1'b0;
            dec_hash_hit <= 1'b0;
        end else if (last) begin
            dec_valid    <= 1'b1;
            dec_accept   <= accept_now;
            dec_mcast    <= mcast_now;
            dec_hash_hit <= hit_now;
        end
    end

endmodule

// File: rtl/addr_hash_filter.sv
module addr_hash_filter
    import hfilt_pkg::*;
#(
    parameter int unsigned CFG_DATA_W = 32,
    parameter int unsigned CFG_ADDR_W = 2
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_start,
    input  logic                  byte_valid,
    input  logic [HF_BYTE_W-1:0]  byte_data,
    input  logic                  cfg_wr,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [CFG_DATA_W-1:0] cfg_wdata,
    output logic                  dec_valid,
    output logic                  dec_accept,
    output logic                  dec_mcast,
    output logic                  dec_hash_hit
);

    hf_ctrl_t               ctrl;
    logic [HF_TBL_BITS-1:0] hash_tbl;
    logic [HF_IDX_W-1:0]    idx_nxt;
    logic                   da0_q;
    logic                   take;
    logic [HF_POS_W-1:0]    pos;
    logic                   hash_bit, hit_now, accept_now;

    hfilt_cfg_regs #(
        .DATA_W (CFG_DATA_W),
        .ADDR_W (CFG_ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .ctrl     (ctrl),
        .hash_tbl (hash_tbl)
    );

    hfilt_index_acc u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (frame_start),
        .take    (take),
        .pos     (pos),
        .byte_in (byte_data),
        .idx_nxt (idx_nxt),
        .da0_q   (da0_q)
    );

    assign hash_bit   = hash_tbl[idx_nxt];
    assign hit_now    = hash_bit && (da0_q ? ctrl.mc_en : ctrl.uc_en);
    assign accept_now = ctrl.copy_all || hit_now;

    hfilt_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .byte_valid   (byte_valid),
        .accept_now   (accept_now),
        .mcast_now    (da0_q),
        .hit_now      (hit_now),
        .take         (take),
        .pos          (pos),
        .dec_valid    (dec_valid),
        .dec_accept   (dec_accept),
        .dec_mcast    (dec_mcast),
        .dec_hash_hit (dec_hash_hit)
    );

endmodule

// File: rtl/hfilt_checker.sv
module hfilt_checker (
    input logic clk,
    input logic rst_n,
    input logic frame_start,
    input logic byte_valid,
    input logic dec_valid,
    input logic dec_accept,
    input logic dec_mcast,
    input logic dec_hash_hit
);

    assert_valid_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) |-> ($past(byte_valid) && !$past(frame_start)));

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !dec_valid);

    assert_decision_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !frame_start) |=>
            (dec_valid && $stable(dec_accept) && $stable(dec_mcast) && $stable(dec_hash_hit)));

    assert_hit_implies_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hash_hit |-> (dec_accept && dec_valid));

endmodule

bind addr_hash_filter hfilt_checker u_hfilt_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .byte_valid   (byte_valid),
    .dec_valid    (dec_valid),
    .dec_accept   (dec_accept),
    .dec_mcast    (dec_mcast),
    .dec_hash_hit (dec_hash_hit)
);

// File: tb/addr_hash_filter_bench.sv
`timescale 1ns/1ps
module addr_hash_filter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        dec_valid, dec_accept, dec_mcast, dec_hash_hit;

    int n_vec = 0;
    int n_bad = 0;

    logic [2:0]  m_ctrl = '0;   // {mc_en, uc_en, copy_all}
    logic [63:0] m_hash = '0;

    always #4 clk = ~clk;

    addr_hash_filter u_addr_hash_filter (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_mcast(dec_mcast),
        .dec_hash_hit(dec_hash_hit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        case (a)
            2'd0: m_ctrl = d[2:0];
            2'd1: m_hash[31:0] = d;
            2'd2: m_hash[63:32] = d;
            default: ;
        endcase
    endtask

    task automatic set_hash(input logic [63:0] h);
        wr(2'd1, h[31:0]);
        wr(2'd2, h[63:32]);
    endtask

    function automatic logic [5:0] exp_idx(input logic [47:0] da);
        logic [5:0] r = '0;
        for (int n = 0; n < 48; n++) r[n % 6] = r[n % 6] ^ da[n];
        return r;
    endfunction

    // Sends frame_start, then the six bytes of da (byte k = da[8k+:8]); checks the decision.
    task automatic run_frame(input logic [47:0] da, input bit junk, input bit gaps, input string tag);
        logic [5:0] ix;
        logic mc, hit, acc;
        @(negedge clk);
        frame_start = 1'b1;
        byte_valid = junk;
        byte_data = ~da[7:0];
        @(negedge clk);
        frame_start = 1'b0;
        byte_valid = 1'b0;
        chk({"R8 cleared ", tag}, 32'(dec_valid), 32'd0);
        for (int k = 0; k < 6; k++) begin
            byte_valid = 1'b1;
            byte_data = da[8*k +: 8];
            if (k < 5) begin
                @(negedge clk);
                if (gaps) begin
                    byte_valid = 1'b0;
                    byte_data = 8'hA5;
                    @(negedge clk);
                end
            end
        end
        chk({"R3 not yet valid ", tag}, 32'(dec_valid), 32'd0);
        @(negedge clk);
        byte_valid = 1'b0;
        ix  = exp_idx(da);
        mc  = da[0];
        hit = m_hash[ix] && (mc ? m_ctrl[2] : m_ctrl[1]);
        acc = m_ctrl[0] || hit;
        chk({"R3 valid ", tag}, 32'(dec_valid), 32'd1);
        chk({"R5 mcast ", tag}, 32'(dec_mcast), 32'(mc));
        chk({"R4 R6 hash hit ", tag}, 32'(dec_hash_hit), 32'(hit));
        chk({"R7 accept ", tag}, 32'(dec_accept), 32'(acc));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] pats [3];
        logic [47:0] da;
        pats[0] = 64'h0;
        pats[1] = '1;
        pats[2] = 64'h0F0F_3C3C_A5A5_9669;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", 32'(dec_valid), 32'd0);
        chk("R1 accept", 32'(dec_accept), 32'd0);
        chk("R1 mcast", 32'(dec_mcast), 32'd0);
        chk("R1 hit", 32'(dec_hash_hit), 32'd0);
        run_frame(48'h1234_5678_9AB1, 1'b0, 1'b0, "R1 unconfigured");

        // R4 index sweep: byte0 = v gives index v; one-hot table at v, then at v^1
        wr(2'd0, 32'h6);
        for (int v = 0; v < 64; v++) begin
            set_hash(64'd1 << v);
            run_frame({40'h0, 2'b00, 6'(v)}, 1'b0, 1'b0, "R4 sweep onehot");
            set_hash(64'd1 << (v ^ 1));
            run_frame({40'h0, 2'b00, 6'(v)}, 1'b0, 1'b0, "R4 sweep neighbour");
        end

        // R5 R6 R7 R10 config x pattern x address sweep, with and without byte gaps
        for (int c = 0; c < 8; c++) begin
            wr(2'd0, 32'(c));
            for (int p = 0; p < 3; p++) begin
                set_hash(pats[p]);
                for (int a = 0; a < 24; a++) begin
                    for (int k = 0; k < 6; k++) da[8*k +: 8] = 8'((a * 37 + k * 91 + a * k * 13) & 255);
                    da[0] = a[0];
                    run_frame(da, 1'b0, a[1], "R5 R6 R7 R10 sweep");
                end
            end
        end

        // R8 byte in the frame_start cycle is not taken
        wr(2'd0, 32'h2);
        set_hash(64'h5A5A_0FF0_1234_8001);
        for (int a = 0; a < 8; a++) begin
            run_frame({8'(a * 29), 8'h11, 8'(a * 7), 8'h3C, 8'(a * 53), 8'(a * 2)}, 1'b1, 1'b0, "R8 start byte");
        end

        // R2 write to address 3 has no effect
        wr(2'd0, 32'h4);
        set_hash('1);
        wr(2'd3, 32'h0);
        run_frame(48'hFFEE_DDCC_BBAB, 1'b0, 1'b0, "R2 addr3 ignored mc");
        run_frame(48'hFFEE_DDCC_BBAA, 1'b0, 1'b0, "R2 R10 unicast rejected");

        // R9 decision holds against extra bytes and register writes
        run_frame(48'h0102_0304_0507, 1'b0, 1'b0, "R9 setup");
        byte_valid = 1'b1; byte_data = 8'hFE;
        repeat (3) @(negedge clk);
        byte_valid = 1'b0;
        wr(2'd0, 32'h0);
        set_hash(64'h0);
        @(negedge clk);
        chk("R9 hold valid", 32'(dec_valid), 32'd1);
        chk("R9 hold accept", 32'(dec_accept), 32'd1);
        chk("R9 hold mcast", 32'(dec_mcast), 32'd1);
        chk("R9 hold hit", 32'(dec_hash_hit), 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule